// File: doc/BRIEF.md
# Four-Lane Seven-to-One Deserializer with Output Bit Remap

This block turns four serial data lanes into a 28-bit parallel word. A fifth lane carries a sampled copy of the transmitter's frame clock. Every input is sampled on the rising edge of a bit clock that runs at seven times the frame rate. The block finds the frame boundary in the clock lane and shifts seven bits per frame into a register for each lane. Once per frame it loads all 28 bits into the parallel output register. The lanes do not map to contiguous output ranges. Each lane feeds a fixed, scattered set of output indices.

A frame-rate output clock is produced from the seven-slot bit counter. The output register updates one bit period before that clock rises, so the word is stable at the rising edge. The block keeps checking the clock lane against its expected pattern. On a mismatch it sets a sticky lock-lost flag, drops the frame being received and hunts for the next boundary.

An active-low run input works as an asynchronous clear. While it is low the output clock stops, and every register and output reads 0.

The framing controller has three states:
- `ST_HUNT` searches for a boundary.
- `ST_FILL` is aligned and collects the first frame after a (re)sync.
- `ST_RUN` is aligned, and each new frame hands the previous frame to the outputs.

The transitions are:
- boundary seen: `ST_HUNT` to `ST_FILL`.
- first frame good: `ST_FILL` to `ST_RUN` at slot 6.
- mismatch: `ST_FILL` or `ST_RUN` to `ST_HUNT`.
- frame wrap: `ST_RUN` to `ST_RUN` at slot 6.
- shutdown: any state to `ST_HUNT`.

Top module: `quad_deser7`

## Requirements
- R1: Serial slot s (s = 0 first, 6 last) of each lane lands on the following output bits of `par_out`:
  - lane 0, slots 0..6: bits 7,6,4,3,2,1,0
  - lane 1, slots 0..6: bits 18,15,14,13,12,9,8
  - lane 2, slots 0..6: bits 26,25,24,22,21,20,19
  - lane 3, slots 0..6: bits 23,17,16,11,10,5,27
- R2: In `ST_RUN`, the rising `clk_bit` edge that samples slot 0 of a frame loads the whole previous frame into `par_out`. `par_out` then holds that word until the next frame's slot-0 edge.
- R3: While aligned, `frame_clk` is 1 after the edges that sample slots 1 through 4 and 0 after all other edges. It therefore rises one bit period after `par_out` updates, and `par_out` never changes while `frame_clk` is high.
- R4: The clock lane carries 1,1,0,0,0,1,1 in slots 0..6. In `ST_HUNT`, three consecutive samples of 0,1,1 mark the last of them as slot 6, and the next sample is slot 0. Samples held at 1 before the first frame cause no lock.
- R5: After the run input is released, `par_out` stays 0 and `frame_valid` stays 0 until the first transfer of a complete aligned frame. `frame_valid` goes to 1 with that transfer and stays 1.
- R6: In `ST_FILL` or `ST_RUN`, a clock-lane sample that differs from the pattern bit for its slot has these effects:
  - `lock_lost` goes to 1 and stays at 1.
  - `frame_clk` goes to 0.
  - The frame in progress is never output.
  - The next complete frame after the next detected boundary is output.
- R7: While `run_n` is 0, `par_out`, `frame_clk`, `frame_valid` and `lock_lost` are 0, with no clock edge needed.
- R8: In `ST_HUNT`, `frame_clk` stays 0 and `par_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit-rate sampling clock, seven times the frame rate |
| run_n | input | 1 | Active-low shutdown; asynchronous clear of all state |
| lane_in | input | 4 | Serial data lanes, bit l is lane l |
| clk_lane | input | 1 | Sampled frame clock lane |
| par_out | output | 28 | Remapped parallel word |
| frame_clk | output | 1 | Frame-rate output clock, high four bit periods of seven |
| frame_valid | output | 1 | Set with the first transfer after shutdown release |
| lock_lost | output | 1 | Sticky flag for a clock-lane pattern mismatch |

## Verification
The bench builds the block with its only configuration: four lanes of seven slots and the fixed remap table. This small size makes a walking-one sweep over all 28 output positions practical, so every single slot-to-output route is checked on its own, with dense and pseudo-random words added on top. Frames are serialized from the R1 table and compared against the sent word at every bit slot. That comparison also pins down when the transfer happens and the high and low slots of the output clock. A corrupted clock-lane frame exercises the mismatch path and the frame drop. A mid-stream shutdown shows the clear and the return to lock.

// File: rtl/sdes7_pkg.sv
package sdes7_pkg;

    localparam int NLANE  = 4;
    localparam int NSLOT  = 7;
    localparam int NOUT   = NLANE * NSLOT;
    localparam int SLOT_W = $clog2(NSLOT);

    // Clock lane value per slot, bit s = slot s (slots 0..6 = 1,1,0,0,0,1,1)
    localparam logic [NSLOT-1:0] CLK_PATTERN = 7'b1100011;

    // Slots after whose sampling edge the output clock is high
    localparam int HI_FIRST = 1;
    localparam int HI_LAST  = 4;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_FILL   = 2'd1,
        ST_RUN    = 2'd2
    } frame_state_e;

    // Output bit fed by a given lane and serial slot
    function automatic int unsigned out_index(input int unsigned lane, input int unsigned slot);
        case (lane * NSLOT + slot)
            0:  return 7;   1:  return 6;   2:  return 4;   3:  return 3;
            4:  return 2;   5:  return 1;   6:  return 0;
            7:  return 18;  8:  return 15;  9:  return 14;  10: return 13;
            11: return 12;  12: return 9;   13: return 8;
            14: return 26;  15: return 25;  16: return 24;  17: return 22;
            18: return 21;  19: return 20;  20: return 19;
            21: return 23;  22: return 17;  23: return 16;  24: return 11;
            25: return 10;  26: return 5;   27: return 27;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/sdes7_lane_shift.sv
module sdes7_lane_shift #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    output logic [WIDTH-1:0] word
);

    // Oldest sample ends up in the MSB after WIDTH edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else begin
            word <= {word[WIDTH-2:0], din};
        end
    end

endmodule

// File: rtl/sdes7_frame_fsm.sv
module sdes7_frame_fsm
    import sdes7_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clk_lane,
    output logic xfer,
    output logic frame_clk,
    output logic lock_lost
);

    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NSLOT - 1);

    frame_state_e      state, state_nxt;
    logic [SLOT_W-1:0] slot, slot_nxt;
    logic [1:0]        hist;
    logic              match;
    logic              boundary;
    logic              aligned;

    assign match    = (clk_lane == CLK_PATTERN[slot]);
    assign boundary = (hist == 2'b01) && clk_lane;
    assign aligned  = (state != ST_HUNT);
    assign xfer     = (state == ST_RUN) && (slot == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HUNT;
            slot  <= '0;
            hist  <= 2'b11;
        end else begin
            state <= state_nxt;
            slot  <= slot_nxt;
            hist  <= {hist[0], clk_lane};
        end
    end

    // Next state and slot counter
    always_comb begin
        state_nxt = state;
        slot_nxt  = '0;
        unique case (state)
            ST_HUNT: begin
                if (boundary) begin
                    state_nxt = ST_FILL;
                end
            end
            ST_FILL: begin
                if (!match) begin
                    state_nxt = ST_HUNT;
                end else if (slot == SLOT_LAST) begin
                    state_nxt = ST_RUN;
                end else begin
                    slot_nxt = slot + 1'b1;
                end
            end
            ST_RUN: begin
                if (!match) begin
                    state_nxt = ST_HUNT;
                end else if (slot != SLOT_LAST) begin
                    slot_nxt = slot + 1'b1;
                end
            end
            default: begin
                state_nxt = ST_HUNT;
            end
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_clk <= 1'b0;
            lock_lost <= 1'b0;
        end else begin
            frame_clk <= aligned && match &&
                         (int'(slot) >= HI_FIRST) && (int'(slot) <= HI_LAST);
            if (aligned && !match) begin
                lock_lost <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/quad_deser7.sv
module quad_deser7
    import sdes7_pkg::*;
(
    input  logic            clk_bit,
    input  logic            run_n,
    input  logic [3:0]      lane_in,
    input  logic            clk_lane,
    output logic [27:0]     par_out,
    output logic            frame_clk,
    output logic            frame_valid,
    output logic            lock_lost
);

    logic [NSLOT-1:0] lane_word [NLANE];
    logic [NOUT-1:0]  remap;
    logic             xfer;

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        sdes7_lane_shift #(.WIDTH(NSLOT)) u_shift (
            .clk   (clk_bit),
            .rst_n (run_n),
            .din   (lane_in[l]),
            .word  (lane_word[l])
        );
        for (genvar s = 0; s < NSLOT; s++) begin : g_slot
            localparam int unsigned IX = out_index(l, s);
            assign remap[IX] = lane_word[l][NSLOT-1-s];
        end
    end

    sdes7_frame_fsm u_fsm (
        .clk       (clk_bit),
        .rst_n     (run_n),
        .clk_lane  (clk_lane),
        .xfer      (xfer),
        .frame_clk (frame_clk),
        .lock_lost (lock_lost)
    );

    always_ff @(posedge clk_bit or negedge run_n) begin
        if (!run_n) begin
            par_out     <= '0;
            frame_valid <= 1'b0;
        end else if (xfer) begin
            par_out     <= remap;
            frame_valid <= 1'b1;
        end
    end

endmodule

// File: rtl/sdes7_checker.sv
module sdes7_checker (
    input logic        clk_bit,
    input logic        run_n,
    input logic [27:0] par_out,
    input logic        frame_clk,
    input logic        frame_valid,
    input logic        lock_lost
);

    p_stable_while_high_r3: assert property (@(posedge clk_bit) disable iff (!run_n)
        frame_clk |-> $stable(par_out));

    p_update_before_rise_r2: assert property (@(posedge clk_bit) disable iff (!run_n)
        !$stable(par_out) |-> !frame_clk);

    p_zero_until_valid_r5: assert property (@(posedge clk_bit) disable iff (!run_n)
        !frame_valid |-> (par_out == '0));

    p_valid_sticky_r5: assert property (@(posedge clk_bit) disable iff (!run_n)
        frame_valid |=> frame_valid);

    p_lost_sticky_r6: assert property (@(posedge clk_bit) disable iff (!run_n)
        lock_lost |=> lock_lost);

    p_lost_stops_clk_r6: assert property (@(posedge clk_bit) disable iff (!run_n)
        $rose(lock_lost) |-> !frame_clk);

    always @(posedge clk_bit) begin
        if (!run_n) begin
            p_shutdown_clear_r7: assert (par_out == '0 && !frame_clk && !frame_valid && !lock_lost);
        end
    end

endmodule

bind quad_deser7 sdes7_checker u_chk (
    .clk_bit     (clk_bit),
    .run_n       (run_n),
    .par_out     (par_out),
    .frame_clk   (frame_clk),
    .frame_valid (frame_valid),
    .lock_lost   (lock_lost)
);

// File: tb/quad_deser7_bench.sv
module quad_deser7_bench;

    localparam int MAPT [4][7] = '{
        '{7, 6, 4, 3, 2, 1, 0},
        '{18, 15, 14, 13, 12, 9, 8},
        '{26, 25, 24, 22, 21, 20, 19},
        '{23, 17, 16, 11, 10, 5, 27}
    };
    localparam logic [6:0] PAT_OK  = 7'b1100011;   // bit s = slot s
    localparam logic [6:0] PAT_BAD = 7'b1101011;   // slot 3 corrupted to 1
    localparam logic [6:0] CLK_NORM = 7'b0111100;  // frame_clk seen before slot s drive
    localparam logic [6:0] CLK_BAD  = 7'b0001100;
    localparam logic [6:0] CLK_NONE = 7'b0000000;

    logic        clk = 1'b0;
    logic        run_n;
    logic [3:0]  lane_in;
    logic        clk_lane;
    logic [27:0] par_out;
    logic        frame_clk;
    logic        frame_valid;
    logic        lock_lost;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    quad_deser7 u_quad_deser7 (
        .clk_bit     (clk),
        .run_n       (run_n),
        .lane_in     (lane_in),
        .clk_lane    (clk_lane),
        .par_out     (par_out),
        .frame_clk   (frame_clk),
        .frame_valid (frame_valid),
        .lock_lost   (lock_lost)
    );

    task automatic check(input bit ok, input string req, input logic [27:0] act, input logic [27:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one frame; checks use values seen before each slot's drive
    task automatic send_frame(input logic [27:0] w, input logic [6:0] pat,
                              input logic [27:0] exp, input bit exp_v,
                              input bit exp_lost, input logic [6:0] clk_mask,
                              input string dtag);
        for (int s = 0; s < 7; s++) begin
            @(negedge clk);
            check(frame_clk == clk_mask[s], "R3 frame_clk slot", 28'(frame_clk), 28'(clk_mask[s]));
            if (s == 0) begin
                check(lock_lost == exp_lost, "R6 lock_lost", 28'(lock_lost), 28'(exp_lost));
            end else begin
                check(par_out == exp, dtag, par_out, exp);
            end
            if (s == 1) begin
                check(frame_valid == exp_v, "R5 frame_valid", 28'(frame_valid), 28'(exp_v));
            end
            for (int l = 0; l < 4; l++) begin
                lane_in[l] = w[MAPT[l][s]];
            end
            clk_lane = pat[s];
        end
    endtask

    initial begin
        logic [27:0] prev;
        logic [27:0] w;
        logic [27:0] w_m1;
        logic [27:0] w_p1;
        run_n    = 1'b0;
        lane_in  = 4'h0;
        clk_lane = 1'b0;
        repeat (3) @(negedge clk);
        check(par_out == '0 && !frame_clk && !frame_valid && !lock_lost,
              "R7 reset state", par_out, 28'h0);
        run_n    = 1'b1;
        clk_lane = 1'b1;
        lane_in  = 4'hF;
        repeat (3) @(negedge clk);   // idle high samples, no lock (R4)

        // F0 locks, F1 fills, nothing shown yet (R4, R5)
        send_frame(28'hFFFFFFF, PAT_OK, 28'h0, 1'b0, 1'b0, CLK_NONE, "R4 no output while hunting");
        send_frame(28'h1234567, PAT_OK, 28'h0, 1'b0, 1'b0, CLK_NORM, "R5 zero before first frame");
        prev = 28'h1234567;

        // Walking one over every output bit (R1)
        for (int i = 0; i < 28; i++) begin
            w = 28'h1 << i;
            send_frame(w, PAT_OK, prev, 1'b1, 1'b0, CLK_NORM, "R1 remap");
            prev = w;
        end

        // Dense and pseudo-random words (R1 R2)
        w = 28'h5A5A5A5;
        for (int k = 0; k < 12; k++) begin
            if (k == 0) w = 28'hFFFFFFF;
            else if (k == 1) w = 28'h5555555;
            else if (k == 2) w = 28'hAAAAAAA;
            else w = 28'(w * 28'd1103515 + 28'd12345);
            send_frame(w, PAT_OK, prev, 1'b1, 1'b0, CLK_NORM, "R2 transfer");
            prev = w;
        end

        // Corrupted clock lane: frame dropped, resync (R6, R8)
        w_m1 = prev;
        send_frame(28'hBADF00D, PAT_BAD, w_m1, 1'b1, 1'b0, CLK_BAD, "R8 hold while hunting");
        w_p1 = 28'h0C0FFEE;
        send_frame(w_p1, PAT_OK, w_m1, 1'b1, 1'b1, CLK_NORM, "R6 dropped frame not shown");
        send_frame(28'h7654321, PAT_OK, w_p1, 1'b1, 1'b1, CLK_NORM, "R6 resync output");
        prev = 28'h7654321;
        send_frame(28'h0000000, PAT_OK, prev, 1'b1, 1'b1, CLK_NORM, "R6 after resync");

        // Shutdown mid-frame (R7), then relock (R5)
        @(negedge clk);
        lane_in  = 4'hA;
        clk_lane = 1'b1;
        #3 run_n = 1'b0;
        #1;
        check(par_out == '0 && !frame_clk && !frame_valid && !lock_lost,
              "R7 async clear", par_out, 28'h0);
        repeat (4) @(negedge clk);
        check(par_out == '0 && !frame_clk && !frame_valid && !lock_lost,
              "R7 held clear", par_out, 28'h0);
        run_n = 1'b1;
        send_frame(28'h1111111, PAT_OK, 28'h0, 1'b0, 1'b0, CLK_NONE, "R5 zero after release");
        send_frame(28'h2468ACE, PAT_OK, 28'h0, 1'b0, 1'b0, CLK_NORM, "R5 zero during fill");
        send_frame(28'h9999999, PAT_OK, 28'h2468ACE, 1'b1, 1'b0, CLK_NORM, "R5 first transfer");
        send_frame(28'h0, PAT_OK, 28'h9999999, 1'b1, 1'b0, CLK_NORM, "R2 after relock");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule